// File: doc/BRIEF.md
# Auto-Reload Down-Counting Timer Channel

This block is one 32-bit timer channel behind a small word-selected register interface. A live count register steps down by one on every prescaled tick while the `start` input is high. When a tick finds the count at zero, the count is refilled from a separate reload register and a sticky underflow flag is raised. The interrupt output is that flag gated by an enable bit in the control word.

Software selects the tick rate through a three-bit field in the control word. Codes 0 to 4 divide the clock by 4, 16, 64, 256 and 1024. Codes 6 and 7 name an external clock source, which is recorded but produces no ticks, and code 5 is reserved. The edge-select and capture-mode fields are stored and read back only. A write that carries illegal content is discarded and raises a sticky error output. An optional capture register is present when the channel is built with that feature.

Top module: `reload_timer_chan`

## Requirements
- R1: After reset, the reload and count registers read all ones, the control word (select 2) reads 0, and `irq` and `cfg_err` are low.
- R2: With rate codes 0, 1, 2, 3 and 4 in control bits [2:0], the count drops by one on every 4th, 16th, 64th, 256th and 1024th rising edge that has `start` high. The prescaler phase is zero after reset.
- R3: A tick that finds the count at 0 loads the reload value and sets the underflow flag, which reads back in control bit 8.
- R4: While `start` is low, the count and the prescaler phase hold and the flag is never set.
- R5: `irq` is high exactly when the underflow flag is set and control bit 5 (interrupt enable) is 1.
- R6: A legal control write with bit 8 = 0 clears the flag. With bit 8 = 1 the flag is left as it was.
- R7: A write to the count register (select 1) replaces the count at the next edge, and it wins over a tick in the same cycle.
- R8: A control write pauses the prescaler for that cycle. The prescaler phase returns to zero only when the written rate code differs from the stored one.
- R9: Rate codes 6 and 7, edge bits [4:3] and capture-mode bits [7:6] are stored and read back, but codes 6 and 7 stop the count. Control bit 9 always reads 0.
- R10: A control write with rate code 5, or with any of bits [31:10] set, leaves the control word and the flag unchanged and sets `cfg_err`. `cfg_err` stays high until reset.
- R11: With `HAS_CAPT`=1, select 3 is a read/write register that resets to 0. With `HAS_CAPT`=0, a write to select 3 sets `cfg_err` and a read returns 0.
- R12: A write to the reload register (select 0) leaves the current count untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Count gate |
| wr_en | input | 1 | Write strobe for the selected register |
| reg_sel | input | 2 | Word select: 0 reload, 1 count, 2 control, 3 capture |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data of the selected register, combinational |
| irq | output | 1 | Underflow interrupt |
| cfg_err | output | 1 | Sticky illegal-write indicator |

## Verification
A register write is sampled at one rising edge and is visible on `rd_data` and `cfg_err` at the following falling edge. `rd_data` follows `reg_sel` with no delay. From a zero prescaler phase at divide N, the first decrement lands on the Nth edge with `start` high, and a cycle that holds a control write adds one edge to that count. The underflow flag and `irq` change in the same cycle as the reload. The bench drives inputs and samples outputs on falling edges, and it counts edges from a known phase so that each check lands one cycle before and exactly on the edge where the value changes.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

    localparam int RATE_W      = 3;
    localparam int PRE_W       = 10;
    localparam int CTRL_KEEP_W = 8;
    localparam int FLAG_BIT    = 8;
    localparam int CAPF_BIT    = 9;
    localparam int RSV_LO      = 10;

    typedef enum logic [1:0] {
        OFS_RELOAD = 2'd0,
        OFS_COUNT  = 2'd1,
        OFS_CTRL   = 2'd2,
        OFS_CAPT   = 2'd3
    } reg_ofs_e;

    typedef struct packed {
        logic [1:0]        cap_mode;
        logic              irq_en;
        logic [1:0]        ext_edge;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    function automatic logic rate_reserved(input logic [RATE_W-1:0] r);
        return r == 3'd5;
    endfunction

    function automatic logic rate_internal(input logic [RATE_W-1:0] r);
        return r <= 3'd4;
    endfunction

    // terminal phase value: 4^(r+1) - 1
    function automatic logic [PRE_W-1:0] rate_last(input logic [RATE_W-1:0] r);
        int sh;
        sh = 2 * (int'(r) + 1);
        if (sh > PRE_W) sh = PRE_W;
        return PRE_W'((32'd1 << sh) - 32'd1);
    endfunction

endpackage

// File: rtl/reload_timer_presc.sv
module reload_timer_presc
    import reload_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    input  logic              rate_chg,
    output logic              tick
);
    logic [PRE_W-1:0] phase_q;
    logic             active;
    logic             at_last;

    assign active  = run && rate_internal(rate);
    assign at_last = (phase_q == rate_last(rate));
    assign tick    = active && at_last;

    always_ff @(posedge clk) begin
        if (rst || rate_chg) begin
            phase_q <= '0;
        end else if (active) begin
            phase_q <= at_last ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/reload_timer_count.sv
module reload_timer_count #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] reload,
    output logic [DATA_W-1:0] cnt_q,
    output logic              uflow
);
    logic at_zero;

    assign at_zero = (cnt_q == '0);
    // a direct write wins over a tick landing in the same cycle
    assign uflow   = tick && !load_en && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '1;
        end else if (load_en) begin
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q <= at_zero ? reload : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/reload_timer_regs.sv
module reload_timer_regs
    import reload_timer_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter bit HAS_CAPT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_ofs_e          ofs,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              uflow,
    output ctrl_t             ctrl_q,
    output logic              flag_q,
    output logic [DATA_W-1:0] reload_q,
    output logic [DATA_W-1:0] capt_q,
    output logic              err_q,
    output logic              rate_chg
);
    logic ctrl_wr;
    logic ctrl_bad;
    logic ctrl_ok;
    logic capt_bad;
    logic unused_capf;

    assign unused_capf = wr_data[CAPF_BIT];
    assign ctrl_wr  = wr_en && (ofs == OFS_CTRL);
    assign ctrl_bad = rate_reserved(wr_data[RATE_W-1:0]) || (|wr_data[DATA_W-1:RSV_LO]);
    assign ctrl_ok  = ctrl_wr && !ctrl_bad;
    assign capt_bad = wr_en && (ofs == OFS_CAPT) && !HAS_CAPT;
    assign rate_chg = ctrl_ok && (wr_data[RATE_W-1:0] != ctrl_q.rate);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            flag_q   <= 1'b0;
            reload_q <= '1;
            err_q    <= 1'b0;
        end else begin
            if (ctrl_ok) begin
                ctrl_q <= ctrl_t'(wr_data[CTRL_KEEP_W-1:0]);
            end
            if (wr_en && (ofs == OFS_RELOAD)) begin
                reload_q <= wr_data;
            end
            if ((ctrl_wr && ctrl_bad) || capt_bad) begin
                err_q <= 1'b1;
            end
            if (uflow) begin
                flag_q <= 1'b1;
            end else if (ctrl_ok && !wr_data[FLAG_BIT]) begin
                flag_q <= 1'b0;
            end
        end
    end

    generate
        if (HAS_CAPT) begin : g_capt
            always_ff @(posedge clk) begin
                if (rst) begin
                    capt_q <= '0;
                end else if (wr_en && (ofs == OFS_CAPT)) begin
                    capt_q <= wr_data;
                end
            end
        end else begin : g_no_capt
            assign capt_q = '0;
        end
    endgenerate
endmodule

// File: rtl/reload_timer_chan.sv
module reload_timer_chan
    import reload_timer_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter bit HAS_CAPT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              cfg_err
);
    reg_ofs_e          ofs;
    ctrl_t             ctrl_q;
    logic              flag_q;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] capt_q;
    logic [DATA_W-1:0] cnt_q;
    logic              rate_chg;
    logic              run;
    logic              tick;
    logic              uflow;

    assign ofs = reg_ofs_e'(reg_sel);
    // counting is paused for the cycle of a control update
    assign run = start && !(wr_en && (ofs == OFS_CTRL));

    reload_timer_regs #(.DATA_W(DATA_W), .HAS_CAPT(HAS_CAPT)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .ofs(ofs), .wr_data(wr_data),
        .uflow(uflow), .ctrl_q(ctrl_q), .flag_q(flag_q), .reload_q(reload_q),
        .capt_q(capt_q), .err_q(cfg_err), .rate_chg(rate_chg)
    );

    reload_timer_presc presc_i (
        .clk(clk), .rst(rst), .run(run), .rate(ctrl_q.rate),
        .rate_chg(rate_chg), .tick(tick)
    );

    reload_timer_count #(.DATA_W(DATA_W)) count_i (
        .clk(clk), .rst(rst), .tick(tick),
        .load_en(wr_en && (ofs == OFS_COUNT)), .load_val(wr_data),
        .reload(reload_q), .cnt_q(cnt_q), .uflow(uflow)
    );

    assign irq = flag_q && ctrl_q.irq_en;

    always_comb begin
        rd_data = '0;
        case (ofs)
            OFS_RELOAD: rd_data = reload_q;
            OFS_COUNT:  rd_data = cnt_q;
            OFS_CTRL: begin
                rd_data[CTRL_KEEP_W-1:0] = ctrl_q;
                rd_data[FLAG_BIT]        = flag_q;
            end
            default:    rd_data = capt_q;
        endcase
    end
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              wr_en,
    input logic [1:0]        reg_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] count,
    input logic [DATA_W-1:0] reload,
    input logic [7:0]        ctrl_bits,
    input logic              flag,
    input logic              err,
    input logic              irq
);
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    assert_load_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel == 2'd1) |=> (count == $past(wr_data)));

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en && reg_sel == 2'd1) && count != $past(count)) |->
        (count == $past(count) - ONE || ($past(count) == '0 && count == $past(reload))));

    assert_flag_start_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(start));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    assert_discard_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel == 2'd2 && wr_data[2:0] == 3'd5) |=> ($stable(ctrl_bits) && err));

    assert_irq_flag_R5: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);
endmodule

bind reload_timer_chan reload_timer_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .count(cnt_q), .reload(reload_q), .ctrl_bits(ctrl_q),
    .flag(flag_q), .err(cfg_err), .irq(irq)
);

// File: tb/reload_timer_chan_tb.sv
`timescale 1ns/1ps
module reload_timer_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wr_en = 1'b0;
    logic        nc_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data, nc_rd_data;
    logic        irq, nc_irq, cfg_err, nc_err;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    reload_timer_chan #(.DATA_W(32), .HAS_CAPT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .cfg_err(cfg_err)
    );

    reload_timer_chan #(.DATA_W(32), .HAS_CAPT(1'b0)) dut_nocap_i (
        .clk(clk), .rst(rst), .start(start), .wr_en(nc_wr), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(nc_rd_data), .irq(nc_irq), .cfg_err(nc_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        reg_sel = s;
        #0.5;
        v = rd_data;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        wr_en = 1'b1; reg_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; start = 1'b0; wr_en = 1'b0; nc_wr = 1'b0;
        cyc(2);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(2'd0, v); chk("R1 reload", v, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R1 count", v, 32'hFFFF_FFFF);
        rd(2'd2, v); chk("R1 ctrl", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 err", {31'b0, cfg_err}, 32'h0);
    endtask

    task automatic t_rates();
        logic [31:0] v;
        for (int r = 0; r < 5; r++) begin
            int div;
            div = 4 ** (r + 1);
            do_reset();
            wr(2'd1, 32'd10);
            wr(2'd2, 32'(r));
            start = 1'b1;
            cyc(div - 1);
            rd(2'd1, v); chk($sformatf("R2 rate %0d before", r), v, 32'd10);
            cyc(1);
            rd(2'd1, v); chk($sformatf("R2 rate %0d step", r), v, 32'd9);
            start = 1'b0;
        end
    endtask

    task automatic t_underflow();
        logic [31:0] v;
        do_reset();
        wr(2'd0, 32'h55);
        rd(2'd1, v); chk("R12 count kept", v, 32'hFFFF_FFFF);
        wr(2'd1, 32'd2);
        wr(2'd2, 32'h20);
        start = 1'b1;
        cyc(11);
        rd(2'd1, v); chk("R3 at zero", v, 32'h0);
        chk("R5 irq low", {31'b0, irq}, 32'h0);
        cyc(1);
        rd(2'd1, v); chk("R3 reloaded", v, 32'h55);
        rd(2'd2, v); chk("R3 flag set", v, 32'h120);
        chk("R5 irq high", {31'b0, irq}, 32'h1);
        start = 1'b0;
        wr(2'd2, 32'h120);
        rd(2'd2, v); chk("R6 flag kept", v, 32'h120);
        wr(2'd2, 32'h000);
        rd(2'd2, v); chk("R6 flag cleared", v, 32'h000);
        chk("R6 irq cleared", {31'b0, irq}, 32'h0);
        wr(2'd1, 32'd0);
        start = 1'b1;
        cyc(4);
        start = 1'b0;
        rd(2'd2, v); chk("R5 flag no enable", v, 32'h100);
        chk("R5 irq masked", {31'b0, irq}, 32'h0);
        wr(2'd2, 32'h120);
        chk("R5 irq enabled", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        do_reset();
        wr(2'd1, 32'd0);
        wr(2'd2, 32'h20);
        cyc(50);
        rd(2'd1, v); chk("R4 count held", v, 32'h0);
        rd(2'd2, v); chk("R4 no flag", v, 32'h20);
        start = 1'b1; cyc(2);
        start = 1'b0; cyc(20);
        start = 1'b1; cyc(1);
        rd(2'd1, v); chk("R4 phase held", v, 32'h0);
        cyc(1);
        start = 1'b0;
        rd(2'd1, v); chk("R4 resumed reload", v, 32'hFFFF_FFFF);
        chk("R4 irq after resume", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_load_prio();
        logic [31:0] v;
        do_reset();
        wr(2'd1, 32'd5);
        start = 1'b1;
        cyc(3);
        wr(2'd1, 32'h100);
        rd(2'd1, v); chk("R7 write wins", v, 32'h100);
        cyc(3);
        rd(2'd1, v); chk("R7 holds", v, 32'h100);
        cyc(1);
        rd(2'd1, v); chk("R7 then steps", v, 32'hFF);
        start = 1'b0;
    endtask

    task automatic t_pause();
        logic [31:0] v;
        do_reset();
        start = 1'b1;
        cyc(1);
        wr(2'd2, 32'h20);
        cyc(2);
        rd(2'd1, v); chk("R8 paused", v, 32'hFFFF_FFFF);
        cyc(1);
        rd(2'd1, v); chk("R8 after pause", v, 32'hFFFF_FFFE);
        start = 1'b0;
        do_reset();
        start = 1'b1; cyc(2); start = 1'b0;
        wr(2'd2, 32'h1);
        wr(2'd2, 32'h0);
        start = 1'b1;
        cyc(3);
        rd(2'd1, v); chk("R8 phase reset wait", v, 32'hFFFF_FFFF);
        cyc(1);
        rd(2'd1, v); chk("R8 phase reset step", v, 32'hFFFF_FFFE);
        start = 1'b0;
        do_reset();
        start = 1'b1; cyc(2); start = 1'b0;
        wr(2'd2, 32'h20);
        start = 1'b1;
        cyc(1);
        rd(2'd1, v); chk("R8 phase kept wait", v, 32'hFFFF_FFFF);
        cyc(1);
        rd(2'd1, v); chk("R8 phase kept step", v, 32'hFFFF_FFFE);
        start = 1'b0;
    endtask

    task automatic t_ext();
        logic [31:0] v;
        do_reset();
        wr(2'd2, 32'h2BE);
        rd(2'd2, v); chk("R9 fields stored", v, 32'h0BE);
        chk("R9 no error", {31'b0, cfg_err}, 32'h0);
        start = 1'b1;
        cyc(300);
        start = 1'b0;
        rd(2'd1, v); chk("R9 no counting", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_err();
        logic [31:0] v;
        do_reset();
        wr(2'd2, 32'h21);
        rd(2'd2, v); chk("R10 legal write", v, 32'h21);
        wr(2'd2, 32'h5);
        rd(2'd2, v); chk("R10 rate5 discarded", v, 32'h21);
        chk("R10 err set", {31'b0, cfg_err}, 32'h1);
        wr(2'd2, 32'h400);
        rd(2'd2, v); chk("R10 reserved bit discarded", v, 32'h21);
        wr(2'd2, 32'h0);
        rd(2'd2, v); chk("R10 later legal write", v, 32'h0);
        chk("R10 err sticky", {31'b0, cfg_err}, 32'h1);
        do_reset();
        chk("R1 err cleared by reset", {31'b0, cfg_err}, 32'h0);
    endtask

    task automatic t_capt();
        logic [31:0] v;
        do_reset();
        rd(2'd3, v); chk("R11 capture reset", v, 32'h0);
        wr(2'd3, 32'hCAFE_1234);
        rd(2'd3, v); chk("R11 capture rw", v, 32'hCAFE_1234);
        chk("R11 capture no err", {31'b0, cfg_err}, 32'h0);
        nc_wr = 1'b1; reg_sel = 2'd3; wr_data = 32'h1234_5678;
        @(negedge clk);
        nc_wr = 1'b0;
        #0.5;
        chk("R11 absent capture err", {31'b0, nc_err}, 32'h1);
        chk("R11 absent capture reads 0", nc_rd_data, 32'h0);
    endtask

    initial begin
        t_reset();
        t_rates();
        t_underflow();
        t_stop();
        t_load_prio();
        t_pause();
        t_ext();
        t_err();
        t_capt();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule